// File: doc/BRIEF.md
# Two-Cycle Ready Latency Stream Receive Adapter

This block sits between a packet source and a consumer. The source may only present a beat in a cycle that follows, by exactly two clocks, a cycle in which the adapter held its ready output high. The consumer side uses an ordinary zero-latency valid/ready handshake. Between the two sides the adapter keeps a small FIFO. It drives ready toward the source from its own fill level and from the beats it has already granted, so a beat that arrives inside the latency window always finds a free slot. Each beat keeps its start-of-packet, end-of-packet, error and non-posted flags, and beats leave in the order they arrived.

The consumer can raise a non-posted stop input at any time. The adapter passes this input straight to the source. It also counts the non-posted packets it hands out while the input stays high. Once the count reaches a parameterised limit, a non-posted packet at the head of the FIFO is held back until the input falls. A beat that arrives in a cycle without credit is discarded and reported on a one-cycle violation output.

Top module: `rl2_stream_adapter`

## Requirements
- R1: A synchronous reset empties the FIFO and clears the non-posted count. While reset is high in the previous cycle, `up_ready` is low. `dn_valid` is low in the first cycle after reset.
- R2: `up_ready` is high in a cycle exactly when the adapter is out of reset for at least one cycle and fill + (ready one cycle ago) + (ready two cycles ago) + MARGIN < DEPTH. The FIFO never overflows.
- R3: A beat is accepted only when `up_valid` is high and `up_ready` was high two cycles earlier. A beat offered in any other cycle outside reset is discarded, and `proto_err` is high in that same cycle.
- R4: A beat leaves in a cycle where `dn_valid` and `dn_ready` are both high. The data and the sop, eop, err and np flags leave bit-exact, in arrival order, and no beat is lost or duplicated.
- R5: `dn_valid` is high whenever the FIFO holds a beat, unless R6 blocks it. While `dn_valid` is high and `dn_ready` is low, the outputs hold steady into the next cycle.
- R6: While `np_mask` stays high, at most NP_LIMIT beats that have both sop and np set are delivered. After that, a head beat with sop and np both set keeps `dn_valid` low. The count restarts in any cycle where `np_mask` is low.
- R7: `up_np_stop` equals `np_mask` in the same cycle.
- R8: The data width DW is a parameter, either 64 or 128 bits. All DW bits pass through unchanged.
- R9: A beat accepted into an empty FIFO with no block shows on `dn_valid` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up_ready | output | 1 | Credit to source; grants a beat two cycles later |
| up_valid | input | 1 | Source beat present |
| up_data | input | DW | Source beat data |
| up_sop | input | 1 | First beat of packet |
| up_eop | input | 1 | Last beat of packet |
| up_err | input | 1 | Beat carries an uncorrectable error |
| up_np | input | 1 | Beat belongs to a non-posted request |
| proto_err | output | 1 | Beat offered without credit (discarded) |
| up_np_stop | output | 1 | Non-posted stop request toward source |
| dn_valid | output | 1 | Consumer beat present |
| dn_ready | input | 1 | Consumer accepts beat |
| dn_data | output | DW | Consumer beat data |
| dn_sop | output | 1 | First beat of packet |
| dn_eop | output | 1 | Last beat of packet |
| dn_err | output | 1 | Beat error flag |
| dn_np | output | 1 | Beat non-posted flag |
| np_mask | input | 1 | Consumer asks to stop non-posted requests |

## Verification
A wrong fill count or credit history shows up at once on `up_ready`: the signal disagrees with the rule in R2 in the very cycle the count goes wrong. An overflow caused by the error becomes visible within two cycles, as a beat that disappears from the delivered stream. A wrong read pointer or a corrupted slot appears in the first handshake that exposes it, as a mismatch in data or flags. A wrong non-posted count shows up as `dn_valid` dropping or staying high in the wrong cycle on a head beat with sop and np set. A stale credit history shows up as `proto_err` in the same cycle as the offending beat.

// File: rtl/rl2_pkg.sv
package rl2_pkg;

  typedef struct packed {
    logic sop;
    logic eop;
    logic err;
    logic np;
  } rl2_tag_t;

  localparam int TAG_W = 4;

  // Credit rule: slots already used plus grants still in flight plus the
  // requested margin must leave room for one more grant.
  function automatic logic rl2_may_open(int unsigned fill, int unsigned fly1,
                                        int unsigned fly2, int unsigned margin,
                                        int unsigned depth);
    return (fill + fly1 + fly2 + margin) < depth;
  endfunction

  // A head beat that opens a non-posted packet is held once the allowance
  // under an active mask has been used up.
  function automatic logic rl2_np_hold(logic mask, int unsigned used,
                                       int unsigned limit, rl2_tag_t head,
                                       logic nonempty);
    return mask && (used >= limit) && nonempty && head.sop && head.np;
  endfunction

endpackage

// File: rtl/rl2_credit_gate.sv
module rl2_credit_gate
  import rl2_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int MARGIN = 0,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] fill,
  input  logic          up_valid,
  output logic          up_ready,
  output logic          accept,
  output logic          proto_err
);

  logic run_q;
  logic rdy_d1;
  logic rdy_d2;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      rdy_d1 <= 1'b0;
      rdy_d2 <= 1'b0;
    end else begin
      run_q  <= 1'b1;
      rdy_d1 <= up_ready;
      rdy_d2 <= rdy_d1;
    end
  end

  assign up_ready  = run_q && rl2_may_open(int'(fill), int'(rdy_d1), int'(rdy_d2),
                                           MARGIN, DEPTH);
  assign accept    = up_valid && rdy_d2 && !rst;
  assign proto_err = up_valid && !rdy_d2 && !rst;

  // R1: no credit in the first cycle after reset was sampled
  assert_ready_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> !up_ready);

  // R3: a stored beat always had credit two cycles earlier
  assert_accept_credit_R3: assert property (@(posedge clk) disable iff (rst)
    accept |-> $past(up_ready, 2));

  // R3: a beat without credit is flagged
  assert_violation_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (up_valid && !$past(up_ready, 2)) |-> proto_err);

endmodule

// File: rtl/rl2_beat_fifo.sv
module rl2_beat_fifo #(
  parameter int W     = 68,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] fill,
  output logic          nonempty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp;
  logic [AW-1:0] rp;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (pop)  rp <= rp + AW'(1);
      unique case ({push, pop})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end

  assign rdata    = mem[rp];
  assign nonempty = (fill != '0);

  // R2: a write never lands in a full buffer
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    push |-> (fill < CW'(DEPTH)));

  // R4: a read never happens from an empty buffer
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    pop |-> nonempty);

endmodule

// File: rtl/rl2_np_gate.sv
module rl2_np_gate
  import rl2_pkg::*;
#(
  parameter int NP_LIMIT = 10,
  localparam int NW      = $clog2(NP_LIMIT + 1)
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     mask,
  input  rl2_tag_t head,
  input  logic     nonempty,
  input  logic     dn_ready,
  output logic     dn_valid,
  output logic     pop
);

  logic [NW-1:0] used;
  logic          hold;
  logic          np_start_out;

  assign hold         = rl2_np_hold(mask, int'(used), NP_LIMIT, head, nonempty);
  assign dn_valid     = nonempty && !hold;
  assign pop          = dn_valid && dn_ready;
  assign np_start_out = pop && head.sop && head.np;

  always_ff @(posedge clk) begin
    if (rst || !mask)      used <= '0;
    else if (np_start_out) used <= used + NW'(1);
  end

  // R6: the allowance count never passes the limit
  assert_np_bound_R6: assert property (@(posedge clk) disable iff (rst)
    used <= NW'(NP_LIMIT));

  // R6: no non-posted start leaves under a mask once the allowance is used
  assert_np_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (np_start_out && mask) |-> (used < NW'(NP_LIMIT)));

endmodule

// File: rtl/rl2_stream_adapter.sv
module rl2_stream_adapter
  import rl2_pkg::*;
#(
  parameter int DW       = 64,
  parameter int DEPTH    = 8,
  parameter int MARGIN   = 0,
  parameter int NP_LIMIT = 10
) (
  input  logic          clk,
  input  logic          rst,
  output logic          up_ready,
  input  logic          up_valid,
  input  logic [DW-1:0] up_data,
  input  logic          up_sop,
  input  logic          up_eop,
  input  logic          up_err,
  input  logic          up_np,
  output logic          proto_err,
  output logic          up_np_stop,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [DW-1:0] dn_data,
  output logic          dn_sop,
  output logic          dn_eop,
  output logic          dn_err,
  output logic          dn_np,
  input  logic          np_mask
);

  localparam int W  = DW + TAG_W;
  localparam int CW = $clog2(DEPTH + 1);

  logic          accept;
  logic          pop;
  logic          nonempty;
  logic [CW-1:0] fill;
  logic [W-1:0]  wbeat;
  logic [W-1:0]  rbeat;
  rl2_tag_t      wtag;
  rl2_tag_t      rtag;

  assign wtag  = '{sop: up_sop, eop: up_eop, err: up_err, np: up_np};
  assign wbeat = {up_data, wtag};

  rl2_credit_gate #(.DEPTH(DEPTH), .MARGIN(MARGIN)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .fill      (fill),
    .up_valid  (up_valid),
    .up_ready  (up_ready),
    .accept    (accept),
    .proto_err (proto_err)
  );

  rl2_beat_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .push     (accept),
    .wdata    (wbeat),
    .pop      (pop),
    .rdata    (rbeat),
    .fill     (fill),
    .nonempty (nonempty)
  );

  assign rtag = rl2_tag_t'(rbeat[TAG_W-1:0]);

  rl2_np_gate #(.NP_LIMIT(NP_LIMIT)) u_np (
    .clk      (clk),
    .rst      (rst),
    .mask     (np_mask),
    .head     (rtag),
    .nonempty (nonempty),
    .dn_ready (dn_ready),
    .dn_valid (dn_valid),
    .pop      (pop)
  );

  assign dn_data    = rbeat[W-1:TAG_W];
  assign dn_sop     = rtag.sop;
  assign dn_eop     = rtag.eop;
  assign dn_err     = rtag.err;
  assign dn_np      = rtag.np;
  assign up_np_stop = np_mask;

  // R5: an offered beat that is not taken stays offered and unchanged
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data) && $stable(dn_sop)
                                 && $stable(dn_eop) && $stable(dn_err)));

  // R9: a beat stored into an empty buffer is offered on the next cycle
  assert_fast_path_R9: assert property (@(posedge clk) disable iff (rst)
    (accept && !nonempty && !(up_sop && up_np && np_mask)) |=> dn_valid);

endmodule

// File: tb/sim_rl2_stream_adapter.sv
module sim_rl2_stream_adapter;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 128;
  localparam int DEPTH      = 8;
  localparam int MARGIN     = 0;
  localparam int NPL        = 10;
  localparam int RUN_CYCLES = 8000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          up_ready, proto_err, up_np_stop;
  logic          up_valid = 1'b0;
  logic [DW-1:0] up_data  = '0;
  logic          up_sop = 1'b0, up_eop = 1'b0, up_err = 1'b0, up_np = 1'b0;
  logic          dn_valid;
  logic          dn_ready = 1'b0;
  logic [DW-1:0] dn_data;
  logic          dn_sop, dn_eop, dn_err, dn_np;
  logic          np_mask = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rl2_stream_adapter #(.DW(DW), .DEPTH(DEPTH), .MARGIN(MARGIN), .NP_LIMIT(NPL)) u0 (
    .clk(clk), .rst(rst), .up_ready(up_ready), .up_valid(up_valid), .up_data(up_data),
    .up_sop(up_sop), .up_eop(up_eop), .up_err(up_err), .up_np(up_np),
    .proto_err(proto_err), .up_np_stop(up_np_stop), .dn_valid(dn_valid),
    .dn_ready(dn_ready), .dn_data(dn_data), .dn_sop(dn_sop), .dn_eop(dn_eop),
    .dn_err(dn_err), .dn_np(dn_np), .np_mask(np_mask)
  );

  typedef struct {
    logic [DW-1:0] d;
    logic sop, eop, err, np;
  } beat_t;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // Behavioural reference state
  beat_t m_q[$];
  bit    m_h1 = 0, m_h2 = 0, m_run = 0;
  int    m_np = 0;
  int    sent = 0, flushed = 0, delivered = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW+3:0] act, input logic [DW+3:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit m_exp_ready();
    return m_run && ((m_q.size() + int'(m_h1) + int'(m_h2) + MARGIN) < DEPTH);
  endfunction

  function automatic bit m_exp_valid();
    bit blk;
    if (m_q.size() == 0) return 1'b0;
    blk = np_mask && (m_np >= NPL) && m_q[0].sop && m_q[0].np;
    return !blk;
  endfunction

  // Reference update on every active edge
  always @(posedge clk) begin
    bit er, ev;
    beat_t b;
    er = m_exp_ready();
    ev = m_exp_valid();
    if (rst) begin
      flushed += m_q.size();
      m_q.delete();
      m_h1 = 0; m_h2 = 0; m_run = 0; m_np = 0;
    end else begin
      if (ev && dn_ready) begin
        if (np_mask && m_q[0].sop && m_q[0].np) m_np++;
        void'(m_q.pop_front());
      end
      if (!np_mask) m_np = 0;
      if (up_valid && m_h2) begin
        b.d = up_data; b.sop = up_sop; b.eop = up_eop; b.err = up_err; b.np = up_np;
        m_q.push_back(b);
        sent++;
        if (m_q.size() > DEPTH)
          check(0, "R2", "buffer overflow", DW'(m_q.size()), DW'(DEPTH));
      end
      m_h2 = m_h1;
      m_h1 = er;
      m_run = 1;
    end
  end

  initial begin
    automatic bit ob1 = 0, ob2 = 0;
    automatic int rem = 0;
    automatic bit pnp = 0;
    automatic int run_np = 0;
    automatic int pr_ready = 75;
    automatic bit inject = 0;
    automatic bit sending = 1;
    automatic bit legal, cur;
    @(negedge clk);
    for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
      cur   = up_ready;
      legal = ob2;
      // phase selection
      rst = (cyc < 4) || (cyc >= 7000 && cyc < 4 + 7000);
      if (cyc < 3000)      begin np_mask = 0; pr_ready = 75; inject = 0; end
      else if (cyc < 6000) begin np_mask = ((cyc / 300) % 2) == 1; pr_ready = 90; end
      else if (cyc < 7000) begin np_mask = 0; pr_ready = 50; inject = 1; end
      else if (cyc < 7600) begin pr_ready = 20; inject = 0; end
      else                 begin pr_ready = 100; sending = 0; end
      dn_ready = !rst && (($urandom % 100) < pr_ready);
      up_valid = 0;
      up_data  = {$urandom, $urandom, $urandom, $urandom};
      up_sop = 0; up_eop = 0; up_err = 0; up_np = 0;
      if (!rst && sending && legal && ($urandom % 100) < 80) begin
        if (rem == 0) begin
          rem = 1 + ($urandom % 4);
          pnp = (cyc >= 3000 && cyc < 6000) ? (($urandom % 2) == 0) : (($urandom % 3) == 0);
          up_sop = 1;
        end
        up_eop = (rem == 1);
        up_err = (($urandom % 10) == 0);
        up_np  = pnp;
        up_valid = 1;
        rem--;
      end else if (!rst && inject && !legal && ($urandom % 8) == 0) begin
        up_valid = 1; up_sop = $urandom; up_eop = $urandom; up_np = $urandom;
      end
      #1;
      if (cyc == 0) begin
        check(up_ready == 0, "R1", "up_ready in reset", DW'(up_ready), '0);
        check(dn_valid == 0, "R1", "dn_valid in reset", DW'(dn_valid), '0);
      end
      check(up_ready == m_exp_ready(), "R1/R2", "up_ready", DW'(up_ready), DW'(m_exp_ready()));
      check(proto_err == (up_valid && !m_h2 && !rst), "R3", "proto_err",
            DW'(proto_err), DW'(up_valid && !m_h2 && !rst));
      check(up_np_stop == np_mask, "R7", "up_np_stop", DW'(up_np_stop), DW'(np_mask));
      check(dn_valid == m_exp_valid(), "R5/R6/R9", "dn_valid",
            DW'(dn_valid), DW'(m_exp_valid()));
      if (dn_valid && m_q.size() > 0)
        check({dn_data, dn_sop, dn_eop, dn_err, dn_np} ===
              {m_q[0].d, m_q[0].sop, m_q[0].eop, m_q[0].err, m_q[0].np},
              "R4/R8", "head beat",
              {dn_data, dn_sop, dn_eop, dn_err, dn_np},
              {m_q[0].d, m_q[0].sop, m_q[0].eop, m_q[0].err, m_q[0].np});
      if (!np_mask) run_np = 0;
      if (dn_valid && dn_ready && !rst) begin
        delivered++;
        if (np_mask && dn_sop && dn_np) begin
          run_np++;
          check(run_np <= NPL, "R6", "np starts under mask", DW'(run_np), DW'(NPL));
        end
      end
      ob2 = ob1;
      ob1 = cur;
      @(negedge clk);
    end
    #1;
    check(dn_valid == 0 && m_q.size() == 0, "R4", "drained", DW'(dn_valid), '0);
    check(sent == delivered + flushed, "R4", "beat conservation",
          DW'(delivered + flushed), DW'(sent));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule